// File: doc/BRIEF.md
# Way-Lockable Set-Associative Instruction Cache Controller

This block holds the tags, line-valid bits and replacement state of a read-only instruction cache. The cache has 32 sets of 32 ways, and each line holds eight 32-bit words. A fetch request carries a byte address. The controller splits it into tag, set index and word index, compares the tag against all 32 ways of the indexed set, and on a hit reads the word from an external line-data RAM. Every stored word carries a parity bit. The controller checks that bit before it returns the word.

On a miss, the controller picks a victim way by round-robin. Each set has its own lock count, and the low ways of the set are never chosen as victims. The controller then asks memory for the line, starting at the requested word. That first word goes to the requester in the cycle it arrives, and the remaining seven words follow in wrapping order into the data RAM. When the cache is disabled, each fetch becomes a single-word memory read and no line is allocated.

The line-data RAM sits outside the block. It takes one address per cycle and returns read data one cycle after a read is issued. Its word address is `{set, way, word}`.

Top module: `icache_ctrl`

## Requirements
- R1: After a synchronous reset, `req_ready` is 1 and `rsp_valid`, `mem_req` and `par_err` are 0. Every line is invalid, every lock count is 0 and every round-robin pointer is 0, so the first miss in any set fills way 0.
- R2: A hit raises `rsp_valid` two cycles after the accepting edge, with the stored word on `rsp_data`. It issues no memory request and writes nothing to the data RAM.
- R3: A miss raises `mem_req` for exactly one cycle, one cycle after acceptance. It comes with `mem_burst`=1 and `mem_addr` equal to the request address with bits [1:0] cleared. The first word returned on `mem_valid` appears on `rsp_data`, with `rsp_valid` high, in that same cycle.
- R4: A fill writes eight words to RAM address `{set[12:8], way[7:3], word[2:0]}` in the order critical, critical+1, … modulo 8. `req_ready` stays low until the eighth word is written, and the line becomes valid only then.
- R5: Within one set, successive victims run from the set's lock count up to way 31 and then wrap back to the lock count.
- R6: A set's lock count is written with `lock_we`, `lock_set` and `lock_ways`. Values above 28 are stored as 28. Ways below the lock count are never victims. If the pointer lies below a newly raised lock count, the next victim is the lock count itself.
- R7: Bit 32 of each RAM word is the XOR of its 32 data bits. If a hit word fails this check, `par_err` pulses for one cycle, the line is invalidated and refetched into the same way by a burst, and the response carries the word from memory.
- R8: With `cache_en`=0 at acceptance, the controller issues one request with `mem_burst`=0 and returns the word from `mem_valid`. It makes no RAM write and allocates no line, even when the address is already cached.
- R9: At most one way of the indexed set reports a tag match.
- R10: Each set keeps its own round-robin pointer, so misses in one set do not move the victim choice of another.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cache_en | input | 1 | Cache enable, sampled when a request is accepted |
| lock_we | input | 1 | Write strobe for a set's lock count |
| lock_set | input | 5 | Set whose lock count is written |
| lock_ways | input | 5 | New lock count (clamped to 28) |
| req_valid | input | 1 | Fetch request |
| req_addr | input | 32 | Fetch byte address: tag [31:10], set [9:5], word [4:2] |
| req_ready | output | 1 | Controller idle and able to accept a request |
| rsp_valid | output | 1 | Response word valid |
| rsp_data | output | 32 | Response word |
| par_err | output | 1 | One-cycle pulse on a parity failure of a hit word |
| mem_req | output | 1 | One-cycle memory request |
| mem_burst | output | 1 | 1: eight-word wrapping line fill, 0: single word |
| mem_addr | output | 32 | Word-aligned address of the critical word |
| mem_valid | input | 1 | Memory word valid |
| mem_data | input | 32 | Memory word |
| ram_en | output | 1 | Data RAM access enable |
| ram_we | output | 1 | Data RAM write enable |
| ram_addr | output | 13 | Data RAM word address {set, way, word} |
| ram_wdata | output | 33 | Data RAM write word {parity, data} |
| ram_rdata | input | 33 | Data RAM read word, one cycle after a read |

## Verification
Some properties are checked by assertions on every cycle:
- the tag match in the indexed set is unique;
- no victim lies among the locked ways;
- stored lock counts never exceed 28;
- a memory request lasts one cycle;
- a parity failure always comes with a burst refetch;
- the bypass path never writes the RAM or the tags.

Other behaviours can only be shown by the bench's scenarios:
- the exact order of victims as the pointer wraps past way 31 or jumps over a raised lock count;
- wrapping fill addresses and their stored parity bits;
- same-cycle forwarding of the critical word;
- hit latency;
- the recovery after an injected parity fault.

// File: rtl/icache_pkg.sv
// Package: shared constants, FSM state type and parity helper for the
// instruction cache controller. Assumes a fixed 32-bit fetch word.
package icache_pkg;
    localparam int DATA_W = 32;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOOK,
        ST_READ,
        ST_FILL,
        ST_BREQ,
        ST_BWAIT
    } ic_state_e;

    // Parity bit stored beside a word: XOR of all data bits.
    function automatic logic word_parity(input logic [DATA_W-1:0] d);
        return ^d;
    endfunction
endpackage

// File: rtl/icache_tags.sv
// Module: tag and line-valid store for all sets and ways, with a full
// tag compare across the ways of one indexed set.
// Assumes at most one write per cycle. Tags have no reset; only the valid
// bits are cleared, so stale tags are never matched.
module icache_tags #(
    parameter int SETS  = 32,
    parameter int WAYS  = 32,
    parameter int TAG_W = 22,
    localparam int SET_W = $clog2(SETS),
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SET_W-1:0] rd_set,
    input  logic [TAG_W-1:0] rd_tag,
    output logic             hit,
    output logic [WAY_W-1:0] hit_way,
    input  logic             wr_en,
    input  logic [SET_W-1:0] wr_set,
    input  logic [WAY_W-1:0] wr_way,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic             wr_valid
);
    logic [TAG_W-1:0] tag_q [SETS][WAYS];
    logic [WAYS-1:0]  vld_q [SETS];
    logic [WAYS-1:0]  hit_vec;

    // Per-way match of the indexed set.
    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign hit_vec[w] = vld_q[rd_set][w] && (tag_q[rd_set][w] == rd_tag);
    end

    // Encode the matching way into a way number.
    always_comb begin
        hit_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (hit_vec[w]) hit_way = WAY_W'(w);
        end
    end

    assign hit = |hit_vec;

    // Line-valid bits: cleared by reset, set or cleared by the controller.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) vld_q[s] <= '0;
        end else if (wr_en) begin
            vld_q[wr_set][wr_way] <= wr_valid;
        end
    end

    // Tag capture when a line is completed.
    always_ff @(posedge clk) begin
        if (wr_en && wr_valid) tag_q[wr_set][wr_way] <= wr_tag;
    end

    assert_one_hit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));
endmodule

// File: rtl/icache_repl.sv
// Module: per-set lock counts and round-robin victim pointers.
// Ways below a set's lock count are protected. The pointer steps over the
// remaining ways and wraps back to the lock count after the last way.
// Assumes `adv` is raised only for the set presented on q_set.
module icache_repl #(
    parameter int SETS     = 32,
    parameter int WAYS     = 32,
    parameter int MAX_LOCK = 28,
    localparam int SET_W = $clog2(SETS),
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [SET_W-1:0] cfg_set,
    input  logic [WAY_W-1:0] cfg_cnt,
    input  logic [SET_W-1:0] q_set,
    input  logic             adv,
    output logic [WAY_W-1:0] victim
);
    logic [WAY_W-1:0] lock_q [SETS];
    logic [WAY_W-1:0] ptr_q  [SETS];
    logic [WAY_W-1:0] cnt_clamped;
    logic [WAY_W-1:0] ptr_next;

    // Clamp a requested lock count to the largest lockable number of ways.
    assign cnt_clamped = (cfg_cnt > WAY_W'(MAX_LOCK)) ? WAY_W'(MAX_LOCK) : cfg_cnt;

    // Victim: the pointer, pushed up to the first unlocked way if needed.
    always_comb begin
        victim   = (ptr_q[q_set] < lock_q[q_set]) ? lock_q[q_set] : ptr_q[q_set];
        ptr_next = (victim == WAY_W'(WAYS - 1)) ? lock_q[q_set] : victim + 1'b1;
    end

    // Pointer and lock-count state update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                lock_q[s] <= '0;
                ptr_q[s]  <= '0;
            end
        end else begin
            if (adv)    ptr_q[q_set]    <= ptr_next;
            if (cfg_we) lock_q[cfg_set] <= cnt_clamped;
        end
    end

    assert_victim_unlocked_R6: assert property (@(posedge clk) disable iff (!rst_n)
        adv |-> (victim >= lock_q[q_set]));

    assert_lock_cap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> (lock_q[$past(cfg_set)] <= WAY_W'(MAX_LOCK)));
endmodule

// File: rtl/icache_ctrl.sv
// Module: top of the instruction cache controller.
// It accepts one fetch at a time. The fetch is looked up in the tag store
// and then either read from the external line RAM (hit) or filled from
// memory critical-word-first (miss). With the cache disabled it performs a
// single-word bypass read. Assumes the line RAM returns read data one cycle
// after ram_en, and that memory delivers a burst in wrapping order.
module icache_ctrl
    import icache_pkg::*;
#(
    parameter int SETS     = 32,
    parameter int WAYS     = 32,
    parameter int WORDS    = 8,
    parameter int ADDR_W   = 32,
    parameter int MAX_LOCK = 28,
    localparam int SET_W  = $clog2(SETS),
    localparam int WAY_W  = $clog2(WAYS),
    localparam int WRD_W  = $clog2(WORDS),
    localparam int TAG_W  = ADDR_W - 2 - WRD_W - SET_W,
    localparam int RAM_AW = SET_W + WAY_W + WRD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cache_en,
    input  logic              lock_we,
    input  logic [SET_W-1:0]  lock_set,
    input  logic [WAY_W-1:0]  lock_ways,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              req_ready,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data,
    output logic              par_err,
    output logic              mem_req,
    output logic              mem_burst,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_valid,
    input  logic [DATA_W-1:0] mem_data,
    output logic              ram_en,
    output logic              ram_we,
    output logic [RAM_AW-1:0] ram_addr,
    output logic [DATA_W:0]   ram_wdata,
    input  logic [DATA_W:0]   ram_rdata
);
    ic_state_e         st_q, st_d;
    logic [ADDR_W-1:0] addr_q;
    logic [WAY_W-1:0]  way_q, way_d;
    logic [WRD_W-1:0]  cnt_q, cnt_d;

    logic [SET_W-1:0]  set_a;
    logic [TAG_W-1:0]  tag_a;
    logic [WRD_W-1:0]  word_a;
    logic              hit;
    logic [WAY_W-1:0]  hit_way;
    logic [WAY_W-1:0]  victim;
    logic              tag_we, tag_wv, rr_adv;
    logic [WAY_W-1:0]  tag_way;
    logic              rd_par_ok;

    // Address fields of the request being served.
    assign word_a = addr_q[2 +: WRD_W];
    assign set_a  = addr_q[2 + WRD_W +: SET_W];
    assign tag_a  = addr_q[ADDR_W-1 -: TAG_W];

    icache_tags #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W)) u_tags (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_set   (set_a),
        .rd_tag   (tag_a),
        .hit      (hit),
        .hit_way  (hit_way),
        .wr_en    (tag_we),
        .wr_set   (set_a),
        .wr_way   (tag_way),
        .wr_tag   (tag_a),
        .wr_valid (tag_wv)
    );

    icache_repl #(.SETS(SETS), .WAYS(WAYS), .MAX_LOCK(MAX_LOCK)) u_repl (
        .clk     (clk),
        .rst_n   (rst_n),
        .cfg_we  (lock_we),
        .cfg_set (lock_set),
        .cfg_cnt (lock_ways),
        .q_set   (set_a),
        .adv     (rr_adv),
        .victim  (victim)
    );

    assign req_ready = (st_q == ST_IDLE);
    assign mem_addr  = addr_q & ~ADDR_W'(3);
    assign rd_par_ok = (ram_rdata[DATA_W] == word_parity(ram_rdata[DATA_W-1:0]));

    // Next-state, response, memory, RAM and tag-update decode.
    always_comb begin
        st_d      = st_q;
        way_d     = way_q;
        cnt_d     = cnt_q;
        rsp_valid = 1'b0;
        rsp_data  = '0;
        par_err   = 1'b0;
        mem_req   = 1'b0;
        mem_burst = 1'b1;
        ram_en    = 1'b0;
        ram_we    = 1'b0;
        ram_addr  = {set_a, way_q, word_a};
        ram_wdata = {word_parity(mem_data), mem_data};
        tag_we    = 1'b0;
        tag_way   = way_q;
        tag_wv    = 1'b0;
        rr_adv    = 1'b0;
        case (st_q)
            ST_IDLE: begin
                if (req_valid) st_d = cache_en ? ST_LOOK : ST_BREQ;
            end
            ST_LOOK: begin
                if (hit) begin
                    ram_en   = 1'b1;
                    ram_addr = {set_a, hit_way, word_a};
                    way_d    = hit_way;
                    st_d     = ST_READ;
                end else begin
                    way_d   = victim;
                    rr_adv  = 1'b1;
                    tag_we  = 1'b1;
                    tag_way = victim;
                    mem_req = 1'b1;
                    cnt_d   = '0;
                    st_d    = ST_FILL;
                end
            end
            ST_READ: begin
                if (rd_par_ok) begin
                    rsp_valid = 1'b1;
                    rsp_data  = ram_rdata[DATA_W-1:0];
                    st_d      = ST_IDLE;
                end else begin
                    par_err = 1'b1;
                    tag_we  = 1'b1;
                    mem_req = 1'b1;
                    cnt_d   = '0;
                    st_d    = ST_FILL;
                end
            end
            ST_FILL: begin
                if (mem_valid) begin
                    ram_en   = 1'b1;
                    ram_we   = 1'b1;
                    ram_addr = {set_a, way_q, word_a + cnt_q};
                    if (cnt_q == '0) begin
                        rsp_valid = 1'b1;
                        rsp_data  = mem_data;
                    end
                    cnt_d = cnt_q + 1'b1;
                    if (cnt_q == WRD_W'(WORDS - 1)) begin
                        tag_we = 1'b1;
                        tag_wv = 1'b1;
                        st_d   = ST_IDLE;
                    end
                end
            end
            ST_BREQ: begin
                mem_req   = 1'b1;
                mem_burst = 1'b0;
                st_d      = ST_BWAIT;
            end
            ST_BWAIT: begin
                if (mem_valid) begin
                    rsp_valid = 1'b1;
                    rsp_data  = mem_data;
                    st_d      = ST_IDLE;
                end
            end
            default: st_d = ST_IDLE;
        endcase
    end

    // Controller state registers; the request address is held while busy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            addr_q <= '0;
            way_q  <= '0;
            cnt_q  <= '0;
        end else begin
            st_q  <= st_d;
            way_q <= way_d;
            cnt_q <= cnt_d;
            if (st_q == ST_IDLE && req_valid) addr_q <= req_addr;
        end
    end

    assert_mem_req_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req);

    assert_par_refetch_R7: assert property (@(posedge clk) disable iff (!rst_n)
        par_err |-> (mem_req && mem_burst));

    assert_par_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        par_err |=> !par_err);

    assert_bypass_no_alloc_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_BREQ || st_q == ST_BWAIT) |-> (!ram_we && !tag_we));
endmodule

// File: tb/tb_icache_ctrl.sv
// Bench: behavioural reference (arrays for tags, valid bits, lock counts and
// pointers; a queue logging RAM writes) checked against the controller.
module tb_icache_ctrl;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        cache_en;
    logic        lock_we;
    logic [4:0]  lock_set;
    logic [4:0]  lock_ways;
    logic        req_valid;
    logic [31:0] req_addr;
    logic        req_ready;
    logic        rsp_valid;
    logic [31:0] rsp_data;
    logic        par_err;
    logic        mem_req;
    logic        mem_burst;
    logic [31:0] mem_addr;
    logic        mem_valid;
    logic [31:0] mem_data;
    logic        ram_en;
    logic        ram_we;
    logic [12:0] ram_addr;
    logic [32:0] ram_wdata;
    logic [32:0] ram_rdata;

    int nchk = 0;
    int nerr = 0;
    int nreq = 0;
    int npe  = 0;
    int nrsp = 0;
    bit last_burst;
    logic [31:0] last_maddr;
    int mem_gap = 1;
    bit bubble = 1'b0;

    logic [32:0] ram [int];
    logic [12:0] wlog [$];

    logic [21:0] m_tag [32][32];
    bit          m_vld [32][32];
    bit          m_bad [32][32][8];
    int          m_lock [32];
    int          m_rr [32];

    always #5 clk = ~clk;

    icache_ctrl dut (
        .clk(clk), .rst_n(rst_n), .cache_en(cache_en),
        .lock_we(lock_we), .lock_set(lock_set), .lock_ways(lock_ways),
        .req_valid(req_valid), .req_addr(req_addr), .req_ready(req_ready),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .par_err(par_err),
        .mem_req(mem_req), .mem_burst(mem_burst), .mem_addr(mem_addr),
        .mem_valid(mem_valid), .mem_data(mem_data),
        .ram_en(ram_en), .ram_we(ram_we), .ram_addr(ram_addr),
        .ram_wdata(ram_wdata), .ram_rdata(ram_rdata)
    );

    function automatic logic [31:0] mk(input int tg, input int st, input int wd);
        return {tg[21:0], st[4:0], wd[2:0], 2'b00};
    endfunction

    function automatic logic [31:0] memw(input logic [31:0] a);
        logic [31:0] b;
        b = a & ~32'h3;
        return (b ^ 32'hA5C3_0F1E) * 32'h0001_0003 + 32'h1357;
    endfunction

    task automatic chk(input string r, input longint act, input longint exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s: actual %0h expected %0h", r, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    endtask

    // Line RAM model: one-cycle read latency; logs every write.
    always @(posedge clk) begin
        if (ram_en) begin
            if (ram_we) begin
                ram[int'(ram_addr)] = ram_wdata;
                wlog.push_back(ram_addr);
            end else begin
                ram_rdata <= ram.exists(int'(ram_addr)) ? ram[int'(ram_addr)] : 33'h0;
            end
        end
    end

    // Memory model: answers each request with a wrapping burst or one word.
    initial begin
        mem_valid = 1'b0;
        mem_data  = '0;
        forever begin
            @(negedge clk); #1;
            if (mem_req) begin
                logic [31:0] base;
                int n;
                base = mem_addr;
                nreq++;
                last_burst = mem_burst;
                last_maddr = base;
                n = mem_burst ? 8 : 1;
                repeat (mem_gap) @(negedge clk);
                for (int i = 0; i < n; i++) begin
                    @(negedge clk);
                    if (bubble && i == 4) begin
                        mem_valid = 1'b0;
                        @(negedge clk);
                    end
                    mem_valid = 1'b1;
                    mem_data  = memw({base[31:5], 3'(base[4:2] + 3'(i)), 2'b00});
                end
                @(negedge clk);
                mem_valid = 1'b0;
            end
        end
    end

    // Every-cycle monitor of response and parity pulses.
    initial begin
        forever begin
            @(negedge clk); #1;
            if (rsp_valid) nrsp++;
            if (par_err) npe++;
        end
    end

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        nchk++;
        nerr++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    task automatic set_lock(input int s, input int c);
        @(negedge clk); #1;
        lock_we = 1'b1; lock_set = 5'(s); lock_ways = 5'(c);
        @(negedge clk); #1;
        lock_we = 1'b0;
        m_lock[s] = (c > 28) ? 28 : c;
    endtask

    task automatic corrupt(input logic [31:0] a);
        int s, wd, hw;
        s = int'(a[9:5]); wd = int'(a[4:2]); hw = -1;
        for (int w = 0; w < 32; w++) if (m_vld[s][w] && m_tag[s][w] == a[31:10]) hw = w;
        if (hw >= 0) begin
            logic [12:0] ra;
            ra = {5'(s), 5'(hw), 3'(wd)};
            ram[int'(ra)][32] = ~ram[int'(ra)][32];
            m_bad[s][hw][wd] = 1'b1;
        end
    endtask

    // One fetch: predicts hit/miss/bypass/parity path and checks ports.
    task automatic access(input logic [31:0] a, input bit en, output int way_seen);
        int s, wd, hw, exp_way, k, r0, pe0, rs0;
        bit exp_hit, exp_perr, exp_fill;
        s = int'(a[9:5]); wd = int'(a[4:2]); hw = -1; exp_way = -1;
        for (int w = 0; w < 32; w++) if (m_vld[s][w] && m_tag[s][w] == a[31:10]) hw = w;
        exp_perr = en && hw >= 0 && m_bad[s][hw][wd];
        exp_hit  = en && hw >= 0 && !exp_perr;
        exp_fill = en && !exp_hit;
        if (exp_perr) exp_way = hw;
        else if (exp_fill) begin
            if (m_rr[s] < m_lock[s]) m_rr[s] = m_lock[s];
            exp_way = m_rr[s];
            m_rr[s] = (m_rr[s] == 31) ? m_lock[s] : m_rr[s] + 1;
        end
        while (!req_ready) begin @(negedge clk); #1; end
        wlog.delete();
        r0 = nreq; pe0 = npe; rs0 = nrsp;
        req_valid = 1'b1; req_addr = a; cache_en = en;
        @(negedge clk); #1;
        req_valid = 1'b0;
        k = 0;
        while (!rsp_valid && k < 80) begin @(negedge clk); #1; k++; end
        chk("R2/R3 response word", rsp_data, memw(a));
        if (exp_hit) chk("R2 hit latency", k, 1);
        if (exp_fill) begin
            chk("R3 critical word forwarded with mem_valid", mem_valid, 1);
            chk("R4 not ready during fill", req_ready, 0);
        end
        while (!req_ready) begin @(negedge clk); #1; end
        chk("R2 one response per fetch", nrsp - rs0, 1);
        chk("R3 memory requests", nreq - r0, exp_hit ? 0 : 1);
        if (!exp_hit) begin
            chk("R3/R8 burst kind", last_burst, en);
            chk("R3 memory address", last_maddr, a & ~32'h3);
        end
        chk("R7 parity error pulses", npe - pe0, exp_perr ? 1 : 0);
        if (exp_fill) begin
            chk("R4 fill write count", wlog.size(), 8);
            for (int i = 0; i < 8 && i < wlog.size(); i++) begin
                logic [12:0] ea;
                logic [32:0] rw;
                ea = {5'(s), 5'(exp_way), 3'(wd + i)};
                chk("R4 wrap-order fill address", wlog[i], ea);
                rw = ram[int'(wlog[i])];
                chk("R7 stored parity bit", rw[32], ^rw[31:0]);
                chk("R4 fill word data", rw[31:0], memw({a[31:5], 3'(wd + i), 2'b00}));
            end
            m_vld[s][exp_way] = 1'b1;
            m_tag[s][exp_way] = a[31:10];
            for (int i = 0; i < 8; i++) m_bad[s][exp_way][i] = 1'b0;
        end else begin
            chk("R2/R8 no RAM write", wlog.size(), 0);
        end
        way_seen = (wlog.size() > 0) ? int'(wlog[0][7:3]) : -1;
    endtask

    initial begin
        int ws;
        rst_n = 1'b0; cache_en = 1'b1; lock_we = 1'b0; lock_set = '0; lock_ways = '0;
        req_valid = 1'b0; req_addr = '0;
        for (int s = 0; s < 32; s++) begin
            m_lock[s] = 0; m_rr[s] = 0;
            for (int w = 0; w < 32; w++) begin
                m_vld[s][w] = 1'b0; m_tag[s][w] = '0;
                for (int i = 0; i < 8; i++) m_bad[s][w][i] = 1'b0;
            end
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state at the ports.
        chk("R1 req_ready after reset", req_ready, 1);
        chk("R1 rsp_valid after reset", rsp_valid, 0);
        chk("R1 mem_req after reset", mem_req, 0);
        chk("R1 par_err after reset", par_err, 0);

        // R1/R3/R4: first miss fills way 0 starting at word 2; then hits (R2).
        access(mk(32'h111, 0, 2), 1'b1, ws);
        chk("R1 first victim is way 0", ws, 0);
        access(mk(32'h111, 0, 2), 1'b1, ws);
        access(mk(32'h111, 0, 7), 1'b1, ws);
        access(mk(32'h111, 0, 0), 1'b1, ws);

        // R5: round-robin order in set 2; R4 critical word 5 wraps.
        access(mk(32'h001, 2, 5), 1'b1, ws); chk("R5 victim way", ws, 0);
        access(mk(32'h002, 2, 0), 1'b1, ws); chk("R5 victim way", ws, 1);
        access(mk(32'h003, 2, 7), 1'b1, ws); chk("R5 victim way", ws, 2);
        access(mk(32'h001, 2, 3), 1'b1, ws);

        // R10: set 4 has its own pointer.
        access(mk(32'h004, 4, 1), 1'b1, ws); chk("R10 independent pointer", ws, 0);

        // R6/R5: lock 30 clamps to 28; victims 28..31 then wrap to 28.
        set_lock(3, 30);
        mem_gap = 3; bubble = 1'b1;
        access(mk(32'h010, 3, 4), 1'b1, ws); chk("R6 clamped lock victim", ws, 28);
        access(mk(32'h011, 3, 6), 1'b1, ws); chk("R5 victim way", ws, 29);
        access(mk(32'h012, 3, 1), 1'b1, ws); chk("R5 victim way", ws, 30);
        access(mk(32'h013, 3, 0), 1'b1, ws); chk("R5 victim way", ws, 31);
        access(mk(32'h014, 3, 7), 1'b1, ws); chk("R5 wrap to lock count", ws, 28);
        access(mk(32'h010, 3, 4), 1'b1, ws); chk("R5 evicted line refilled", ws, 29);
        mem_gap = 0; bubble = 1'b0;

        // R6: raising the lock above the pointer moves the victim to it.
        access(mk(32'h020, 1, 2), 1'b1, ws); chk("R5 victim way", ws, 0);
        access(mk(32'h021, 1, 2), 1'b1, ws); chk("R5 victim way", ws, 1);
        set_lock(1, 5);
        access(mk(32'h022, 1, 6), 1'b1, ws); chk("R6 victim jumps to lock count", ws, 5);
        access(mk(32'h020, 1, 2), 1'b1, ws); chk("R6 locked line still hits", ws, -1);

        // R8: disabled fetches go to memory as single words and allocate nothing.
        access(mk(32'h222, 6, 1), 1'b0, ws); chk("R8 no allocation", ws, -1);
        access(mk(32'h222, 6, 1), 1'b1, ws); chk("R8 later enabled fetch misses", ws, 0);
        access(mk(32'h111, 0, 2), 1'b0, ws);

        // R7: corrupted hit word triggers error pulse and refetch into same way.
        corrupt(mk(32'h111, 0, 2));
        access(mk(32'h111, 0, 2), 1'b1, ws); chk("R7 refetch into same way", ws, 0);
        access(mk(32'h111, 0, 2), 1'b1, ws);

        // R4: fill with critical word 5, checked on wrap order inside access.
        access(mk(32'h333, 7, 5), 1'b1, ws); chk("R4 fill way", ws, 0);

        repeat (4) @(negedge clk);
        finish_run();
    end
endmodule